// File: doc/BRIEF.md
# Twin-Output Multi-Mode PWM Generator

This block produces two pulse-width-modulated outputs from one shared up-counter. A 2-bit mode field selects how four byte-wide registers are read. In the off mode both pins go back to ordinary use. The single-output mode has a 16-bit period and a 16-bit duty. The twin 8-bit mode shares one period between both outputs, and the second output has separately programmed rise and fall points, which gives it a phase offset. The twin 16-bit mode runs the counter over its full range and compares each output against its own 16-bit register.

Software writes the mode and the four bytes through a simple write port. Byte writes go into holding copies. The running compare and period values load from those copies only when the counter wraps, so a period is never cut short or glitched. A mode write takes effect at the next clock edge: it restarts the counter at zero and loads the holding copies at once. The counter advances only on cycles where the tick enable is high, so an external prescaler sets the output rate. Two ownership outputs tell the pin multiplexer which pins the generator is driving.

Top module: `pwm_twin`

## Requirements
- R1: In mode 0, pwm0, pwm1, pin0_own and pin1_own are all low and the counter stays at 0.
- R2: In mode 1, the counter runs from 0 up to the 16-bit value of duty register B and then wraps to 0. pwm1 is high while the counter is below the 16-bit value of register A. pwm0 is held low. pin1_own is high and pin0_own is low.
- R3: In mode 1, a register A value of 0 (with a nonzero period) keeps pwm1 low for the whole period. A register A value equal to or above the period value keeps pwm1 high for the whole period.
- R4: In mode 2, the counter runs from 0 up to the low byte of register B and then wraps. pwm0 is high while the counter is below the low byte of register A. pwm0 is held high when that byte is equal to or above the period value.
- R5: In mode 2, pwm1 is high while the counter is at or above the high byte of register B and below the high byte of register A.
- R6: In mode 2, when the high byte of register B is 0 (and the high byte of A is nonzero), pwm0 and pwm1 both rise in the cycle the counter returns to 0.
- R7: In mode 3, the counter runs over the full 0 to 65535 range and the period values are not used. pwm0 is high while the counter is below register A, and pwm1 is high while the counter is below register B. Both pin ownership outputs are high in modes 2 and 3.
- R8: In mode 3, when both registers are nonzero, pwm0 and pwm1 are both high in the cycle the counter returns to 0.
- R9: A byte write changes no output before the counter next wraps. From the wrap onward the new value is in force.
- R10: A mode write is in force one clock edge later, with the counter at 0 and the holding copies loaded.
- R11: While tick_en is low, the counter and both outputs hold their values.
- R12: The write addresses are: 0 for the mode (wr_data[1:0]), 1 for the A low byte, 2 for the A high byte, 3 for the B low byte and 4 for the B high byte. Writes to addresses 5 to 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Counter advance enable (prescaler strobe) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | BYTE_W | Register write data |
| pwm0 | output | 1 | First PWM output |
| pwm1 | output | 1 | Second PWM output |
| pin0_own | output | 1 | Generator owns the first pin |
| pin1_own | output | 1 | Generator owns the second pin |

## Verification
The hardest case to reach from the ports is a byte write that lands in the middle of a running period. It has to change nothing until the wrap, and then change the output at a counter value where the old and new settings give different levels. The stimulus waits on the bench's own model counter until it reaches a chosen value. It then writes a duty that would raise the output at once, checks that the output stays low, and checks again at the same count in the next period. The full 16-bit mode needs one complete pass of 65536 ticks, so the bench spends most of its cycles there, comparing every cycle against the model.

// File: rtl/pwm_twin_pkg.sv
package pwm_twin_pkg;

   localparam int ADDR_W = 3;
   localparam int NUM_BYTES = 4;

   typedef enum logic [1:0] {
      PM_OFF    = 2'd0,
      PM_SINGLE = 2'd1,
      PM_TWIN8  = 2'd2,
      PM_TWIN16 = 2'd3
   } pwm_mode_e;

   localparam logic [ADDR_W-1:0] RA_MODE = 3'd0;

endpackage

// File: rtl/pwm_twin_regs.sv
module pwm_twin_regs
   import pwm_twin_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              reload,
   output logic              mode_wr,
   output pwm_mode_e         mode_q,
   output logic [2*BYTE_W-1:0] duty_a,
   output logic [2*BYTE_W-1:0] duty_b
);

   // holding bytes: 0 A low, 1 A high, 2 B low, 3 B high (address = index + 1)
   logic [NUM_BYTES-1:0][BYTE_W-1:0] hold_q;

   assign mode_wr = wr_en && (wr_addr == RA_MODE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
         mode_q <= PM_OFF;
         duty_a <= '0;
         duty_b <= '0;
      end else begin
         for (int i = 0; i < NUM_BYTES; i++) begin
            if (wr_en && (wr_addr == ADDR_W'(i + 1))) hold_q[i] <= wr_data;
         end
         if (mode_wr) begin
            mode_q <= pwm_mode_e'(wr_data[1:0]);
            duty_a <= hold_q[1:0];
            duty_b <= hold_q[3:2];
         end else if (reload) begin
            duty_a <= hold_q[1:0];
            duty_b <= hold_q[3:2];
         end
      end
   end

endmodule

// File: rtl/pwm_twin_counter.sv
module pwm_twin_counter #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          run,
   input  logic [CW-1:0] limit,
   output logic [CW-1:0] cnt_q,
   output logic          wrap
);

   logic at_limit;

   assign at_limit = (cnt_q == limit);
   assign wrap     = run && !clear && at_limit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clear) begin
         cnt_q <= '0;
      end else if (run) begin
         cnt_q <= at_limit ? '0 : cnt_q + CW'(1);
      end
   end

endmodule

// File: rtl/pwm_twin_outgen.sv
module pwm_twin_outgen
   import pwm_twin_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  pwm_mode_e           mode,
   input  logic [2*BYTE_W-1:0] cnt,
   input  logic [2*BYTE_W-1:0] limit,
   input  logic [2*BYTE_W-1:0] duty_a,
   input  logic [2*BYTE_W-1:0] duty_b,
   output logic                pwm0,
   output logic                pwm1,
   output logic                pin0_own,
   output logic                pin1_own
);

   localparam int CW = 2 * BYTE_W;

   logic [CW-1:0] a_lo, a_hi, b_hi;

   assign a_lo = {{BYTE_W{1'b0}}, duty_a[BYTE_W-1:0]};
   assign a_hi = {{BYTE_W{1'b0}}, duty_a[CW-1:BYTE_W]};
   assign b_hi = {{BYTE_W{1'b0}}, duty_b[CW-1:BYTE_W]};

   always_comb begin
      pwm0     = 1'b0;
      pwm1     = 1'b0;
      pin0_own = 1'b0;
      pin1_own = 1'b0;
      unique case (mode)
         PM_SINGLE: begin
            pin1_own = 1'b1;
            pwm1     = (cnt < duty_a) || (duty_a >= limit);
         end
         PM_TWIN8: begin
            pin0_own = 1'b1;
            pin1_own = 1'b1;
            pwm0     = (cnt < a_lo) || (a_lo >= limit);
            pwm1     = (cnt >= b_hi) && (cnt < a_hi);
         end
         PM_TWIN16: begin
            pin0_own = 1'b1;
            pin1_own = 1'b1;
            pwm0     = cnt < duty_a;
            pwm1     = cnt < duty_b;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/pwm_twin.sv
module pwm_twin
   import pwm_twin_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [BYTE_W-1:0] wr_data,
   output logic              pwm0,
   output logic              pwm1,
   output logic              pin0_own,
   output logic              pin1_own
);

   localparam int CW = 2 * BYTE_W;

   generate
      if (BYTE_W < 2) begin : g_bad_width
         $error("pwm_twin: BYTE_W must be at least 2 to hold the mode field");
      end
   endgenerate

   pwm_mode_e     mode_q;
   logic [CW-1:0] duty_a, duty_b, limit, cnt_q;
   logic          mode_wr, wrap, run;

   always_comb begin
      unique case (mode_q)
         PM_SINGLE: limit = duty_b;
         PM_TWIN8:  limit = {{BYTE_W{1'b0}}, duty_b[BYTE_W-1:0]};
         PM_TWIN16: limit = '1;
         default:   limit = '0;
      endcase
   end

   assign run = tick_en && (mode_q != PM_OFF);

   pwm_twin_regs #(.BYTE_W(BYTE_W)) i_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .reload  (wrap),
      .mode_wr (mode_wr),
      .mode_q  (mode_q),
      .duty_a  (duty_a),
      .duty_b  (duty_b)
   );

   pwm_twin_counter #(.CW(CW)) i_counter (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (mode_wr),
      .run   (run),
      .limit (limit),
      .cnt_q (cnt_q),
      .wrap  (wrap)
   );

   pwm_twin_outgen #(.BYTE_W(BYTE_W)) i_outgen (
      .mode     (mode_q),
      .cnt      (cnt_q),
      .limit    (limit),
      .duty_a   (duty_a),
      .duty_b   (duty_b),
      .pwm0     (pwm0),
      .pwm1     (pwm1),
      .pin0_own (pin0_own),
      .pin1_own (pin1_own)
   );

endmodule

// File: rtl/pwm_twin_chk.sv
module pwm_twin_chk #(
   parameter int BYTE_W = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                tick_en,
   input logic                mode_wr,
   input logic                wrap,
   input logic [1:0]          mode,
   input logic [2*BYTE_W-1:0] cnt,
   input logic [2*BYTE_W-1:0] duty_a,
   input logic [2*BYTE_W-1:0] duty_b,
   input logic                pwm0,
   input logic                pwm1,
   input logic                pin0_own,
   input logic                pin1_own
);

   AST_OFF_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd0) |-> (!pwm0 && !pwm1 && !pin0_own && !pin1_own)); // R1

   AST_OFF_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd0) |-> (cnt == '0)); // R1

   AST_SINGLE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd1) |-> (!pwm0 && pin1_own && !pin0_own)); // R2

   AST_SINGLE_ZERO_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd1 && duty_a == '0 && duty_b != '0) |-> !pwm1); // R3

   AST_TWIN8_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd2) |-> (cnt <= {{BYTE_W{1'b0}}, duty_b[BYTE_W-1:0]})); // R4

   AST_TWIN16_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd3 && cnt == '0 && duty_a != '0 && duty_b != '0) |-> (pwm0 && pwm1)); // R8

   AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_wr && !wrap) |=> ($stable(duty_a) && $stable(duty_b))); // R9

   AST_MODE_WR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      mode_wr |=> (cnt == '0)); // R10

   AST_TICK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_en && !mode_wr) |=> $stable(cnt)); // R11

endmodule

bind pwm_twin pwm_twin_chk #(.BYTE_W(BYTE_W)) i_pwm_twin_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick_en  (tick_en),
   .mode_wr  (mode_wr),
   .wrap     (wrap),
   .mode     (mode_q),
   .cnt      (cnt_q),
   .duty_a   (duty_a),
   .duty_b   (duty_b),
   .pwm0     (pwm0),
   .pwm1     (pwm1),
   .pin0_own (pin0_own),
   .pin1_own (pin1_own)
);

// File: tb/test_pwm_twin.sv
module test_pwm_twin;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b1;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       pwm0, pwm1, pin0_own, pin1_own;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // model state
   int m_mode = 0, m_cnt = 0, m_a = 0, m_b = 0;
   int m_hold[4] = '{0, 0, 0, 0};

   always #10 clk = ~clk;

   pwm_twin i_pwm_twin (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data),
      .pwm0(pwm0), .pwm1(pwm1), .pin0_own(pin0_own), .pin1_own(pin1_own));

   function automatic int m_limit();
      case (m_mode)
         1: return m_b;
         2: return m_b % 256;
         3: return 65535;
         default: return 0;
      endcase
   endfunction

   // {pin1_own, pin0_own, pwm1, pwm0}
   function automatic logic [3:0] m_expect();
      int lim = m_limit();
      logic p0 = 0, p1 = 0, o0 = 0, o1 = 0;
      case (m_mode)
         1: begin o1 = 1; p1 = (m_cnt < m_a) || (m_a >= lim); end
         2: begin
            o0 = 1; o1 = 1;
            p0 = (m_cnt < m_a % 256) || (m_a % 256 >= lim);
            p1 = (m_cnt >= m_b / 256) && (m_cnt < m_a / 256);
         end
         3: begin o0 = 1; o1 = 1; p0 = m_cnt < m_a; p1 = m_cnt < m_b; end
         default: ;
      endcase
      return {o1, o0, p1, p0};
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_mode = 0; m_cnt = 0; m_a = 0; m_b = 0;
         for (int i = 0; i < 4; i++) m_hold[i] = 0;
      end else begin
         if (wr_en && wr_addr == 3'd0) begin
            m_mode = wr_data % 4; m_cnt = 0;
            m_a = m_hold[1] * 256 + m_hold[0];
            m_b = m_hold[3] * 256 + m_hold[2];
         end else if (m_mode != 0 && tick_en) begin
            if (m_cnt == m_limit()) begin
               m_cnt = 0;
               m_a = m_hold[1] * 256 + m_hold[0];
               m_b = m_hold[3] * 256 + m_hold[2];
            end else begin
               m_cnt = m_cnt + 1;
            end
         end
         if (wr_en && wr_addr >= 3'd1 && wr_addr <= 3'd4) m_hold[wr_addr - 1] = wr_data;
      end
   end

   task automatic chk(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0b expected %0b", tag, act, exp);
      end
   endtask

   // every-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         logic [3:0] e = m_expect();
         logic [3:0] a = {pin1_own, pin0_own, pwm1, pwm0};
         string tag;
         case (m_mode)
            0: tag = "R1 cycle";
            1: tag = "R2 cycle";
            2: tag = "R4/R5 cycle";
            default: tag = "R7 cycle";
         endcase
         checks++;
         if (a !== e) begin
            errors++;
            $display("FAIL %s cnt=%0d actual %b expected %b", tag, m_cnt, a, e);
         end
      end
   end

   task automatic wr(input int addr, input int data);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = addr[2:0]; wr_data = data[7:0];
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_cnt(input int n);
      for (int i = 0; i < 70000; i++) begin
         @(negedge clk);
         if (m_cnt == n) return;
      end
      chk("wait_cnt timeout", 1'b1, 1'b0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog actual running expected finished");
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      chk("R1 reset pwm0", pwm0, 1'b0);
      chk("R1 reset pwm1", pwm1, 1'b0);
      chk("R1 reset own0", pin0_own, 1'b0);
      chk("R1 reset own1", pin1_own, 1'b0);
      rst_n = 1'b1;

      // single-output mode, period value 9, duty 3
      wr(3, 9); wr(4, 0); wr(1, 3); wr(2, 0); wr(0, 1);
      chk("R10 mode write pwm1 high at cnt 0", pwm1, 1'b1);
      chk("R12 mode1 own1", pin1_own, 1'b1);
      chk("R12 mode1 own0", pin0_own, 1'b0);
      wait_cnt(3); chk("R2 pwm1 low at duty", pwm1, 1'b0);
      wait_cnt(2); chk("R2 pwm1 high below duty", pwm1, 1'b1);

      // mid-period write must wait for the wrap
      wait_cnt(5); wr(1, 8);
      chk("R9 new duty not yet in force", pwm1, 1'b0);
      wait_cnt(0); wait_cnt(7);
      chk("R9 new duty in force after wrap", pwm1, 1'b1);

      // unmapped addresses
      wr(6, 255); wr(5, 0);
      wait_cnt(0); wait_cnt(7);
      chk("R12 unmapped writes ignored", pwm1, 1'b1);

      // freeze at cnt 7
      tick_en = 1'b0;
      repeat (3) @(negedge clk);
      chk("R11 frozen pwm1", pwm1, 1'b1);
      tick_en = 1'b1;

      // duty extremes
      wr(1, 0); wait_cnt(0);
      for (int i = 0; i < 10; i++) begin
         chk("R3 zero duty low", pwm1, 1'b0);
         @(negedge clk);
      end
      wr(1, 9); wait_cnt(0);
      for (int i = 0; i < 10; i++) begin
         chk("R3 duty at period high", pwm1, 1'b1);
         @(negedge clk);
      end

      // twin 8-bit: period 5, pwm0 duty 2, pwm1 window 1..3
      wr(3, 5); wr(4, 1); wr(1, 2); wr(2, 4); wr(0, 2);
      chk("R12 mode2 own0", pin0_own, 1'b1);
      chk("R12 mode2 own1", pin1_own, 1'b1);
      chk("R5 pwm1 low before rise", pwm1, 1'b0);
      wait_cnt(1);
      chk("R4 pwm0 high", pwm0, 1'b1);
      chk("R5 pwm1 rises", pwm1, 1'b1);
      wait_cnt(2);
      chk("R4 pwm0 falls", pwm0, 1'b0);
      chk("R5 pwm1 still high", pwm1, 1'b1);
      wait_cnt(4); chk("R5 pwm1 falls", pwm1, 1'b0);
      wait_cnt(0);
      chk("R4 pwm0 high after wrap", pwm0, 1'b1);
      chk("R5 pwm1 low after wrap", pwm1, 1'b0);

      wr(4, 0); wait_cnt(0);
      chk("R6 pwm0 rises together", pwm0, 1'b1);
      chk("R6 pwm1 rises together", pwm1, 1'b1);

      // twin 16-bit: A = 3, B = 256 (low byte 0 is not a period here)
      wr(1, 3); wr(2, 0); wr(3, 0); wr(4, 1); wr(0, 3);
      chk("R8 pwm0 high at start", pwm0, 1'b1);
      chk("R8 pwm1 high at start", pwm1, 1'b1);
      wait_cnt(3);
      chk("R7 pwm0 low at match", pwm0, 1'b0);
      chk("R7 pwm1 still high", pwm1, 1'b1);
      wait_cnt(300); chk("R7 counter beyond byte period, pwm1 low", pwm1, 1'b0);
      wait_cnt(0);
      chk("R8 pwm0 high at rollover", pwm0, 1'b1);
      chk("R8 pwm1 high at rollover", pwm1, 1'b1);

      wr(0, 0);
      chk("R1 off pwm0", pwm0, 1'b0);
      chk("R1 off pwm1", pwm1, 1'b0);
      chk("R1 off own0", pin0_own, 1'b0);
      chk("R1 off own1", pin1_own, 1'b0);
      repeat (4) @(negedge clk);
      finish_run();
   end

endmodule